// File: doc/BRIEF.md
# Transceiver Register Bank with Write, Set and Clear Aliases

This block is the register bank on the PHY side of a ULPI-style link. An upstream framer has already turned bus traffic into register commands. Each command gives a direction (read or write), a 6-bit address and write data. The bank applies writes to its control registers and answers reads with one byte, one clock later. The control register contents drive the rest of the transceiver directly through output ports.

Every writable register has three consecutive addresses. The first replaces the whole byte. The second ORs the data into the register. The third uses the data as a mask and clears each bit that is 1 in the mask. The identification, interrupt status, interrupt latch and debug registers can only be read.

An escape address opens an 8-bit extended address space. After a command to 2Fh, the next cycle must supply the extended address. The lower quarter of that space mirrors the immediate registers.

The bank samples a set of status inputs. It records edges on them in an interrupt latch, filtered by two enable registers: one for rising edges and one for falling edges. Reading the latch clears it.

Top module: `ulpi_phy_regbank`

## Requirements
- R1: While `rst` is high at a clock edge, the bank loads these reset values: function control to parameter FUNC_RST (default 41h), interface control to IFC_RST (00h), OTG control to OTG_RST (06h), and all other control registers to 00h. `rd_valid` is 0 after that edge.
- R2: Reads of 00h, 01h, 02h and 03h return the low and high bytes of parameters VENDOR_ID and PRODUCT_ID, in that order.
- R3: A write to the base address of a triple replaces all eight bits of that register. The bases are 04h (function), 07h (interface), 0Ah (OTG), 0Dh (rising enable), 10h (falling enable) and 16h (scratch). A read at base, base+1 or base+2 returns the register.
- R4: A write to base+1 ORs the data into the register.
- R5: A write to base+2 clears each register bit whose data bit is 1, and leaves the other bits unchanged.
- R6: Writes to the ID addresses, to status (13h), to latch (14h) and to debug (15h) change nothing. Debug reads return the `debug_in` input.
- R7: Addresses 19h–2Eh and 30h–3Fh, and extended addresses 40h–FFh, read as 00h. Writes to them change no register.
- R8: A read returns its data with `rd_valid` high in the cycle after the access cycle. The access cycle is the command cycle for an immediate read and the extended-address cycle for an extended read. `rd_valid` is low in every other cycle.
- R9: A command to 2Fh performs no access. If the next cycle has `ext_valid` high and `cmd_valid` low, the access is made at `ext_addr`, with the direction taken from the escape command and the data taken from `cmd_wdata`. Extended addresses 00h–3Fh reach the same registers as the immediate ones.
- R10: A pending extended access is dropped if the next cycle has `ext_valid` low. It is also dropped if that cycle has `cmd_valid` high; that new command is then executed normally. A later `ext_valid` has no effect.
- R11: The status register (13h) holds `status_in` as sampled at the previous clock edge.
- R12: Latch bit i (14h) becomes 1 when `status_in[i]` rises while rising-enable bit i is 1, or falls while falling-enable bit i is 1. It stays 1 until it is read.
- R13: A read of the latch returns its value and clears it. An edge recorded in the same cycle as the read still sets its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_write | input | 1 | 1 for write, 0 for read |
| cmd_addr | input | 6 | Immediate address, 2Fh is the escape |
| cmd_wdata | input | 8 | Write data (also used in the extended cycle) |
| ext_valid | input | 1 | Extended address present this cycle |
| ext_addr | input | 8 | Extended address |
| status_in | input | 8 | Status lines feeding the interrupt registers |
| debug_in | input | 8 | Value returned by the debug register |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| func_ctrl | output | 8 | Function control contents |
| iface_ctrl | output | 8 | Interface control contents |
| otg_ctrl | output | 8 | OTG control contents |

## Verification
Register contents and the control outputs change at the clock edge that ends the access cycle. Read data and `rd_valid` appear after that same edge. For an extended access the access cycle is the cycle after the escape, so results come two edges after the escape command. The bench drives each command on a falling edge and checks on the falling edge after the access cycle, which is one edge for immediate accesses and two for extended ones. Status and latch values are expected one edge after `status_in` changes, so the bench waits one falling edge after each status change before reading.

// File: rtl/ulpi_rb_pkg.sv
package ulpi_rb_pkg;

    localparam int DW   = 8;
    localparam int NCTL = 6;
    localparam int IDXW = $clog2(NCTL);

    localparam logic [5:0] ESC_ADDR = 6'h2F;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_VID_L,
        SEL_VID_H,
        SEL_PID_L,
        SEL_PID_H,
        SEL_CTL,
        SEL_STAT,
        SEL_LATCH,
        SEL_DBG
    } sel_e;

    typedef enum logic [1:0] {
        OP_WR  = 2'd0,
        OP_SET = 2'd1,
        OP_CLR = 2'd2
    } op_e;

    // Base address of control triple i: five packed triples from 04h, scratch at 16h.
    function automatic logic [7:0] ctl_base(int i);
        if (i < 5) return 8'(4 + 3 * i);
        return 8'h16;
    endfunction

endpackage

// File: rtl/ulpi_rb_decode.sv
module ulpi_rb_decode
    import ulpi_rb_pkg::*;
(
    input  logic [7:0]      addr,
    output sel_e            sel,
    output op_e             op,
    output logic [IDXW-1:0] idx
);

    logic [NCTL-1:0] hit;
    logic [1:0]      off [NCTL];

    for (genvar g = 0; g < NCTL; g++) begin : g_tri
        localparam logic [7:0] BASE = ctl_base(g);
        assign hit[g] = (addr >= BASE) && (addr <= BASE + 8'd2);
        assign off[g] = 2'(addr - BASE);
    end

    always_comb begin
        sel = SEL_NONE;
        op  = OP_WR;
        idx = '0;
        case (addr)
            8'h00:   sel = SEL_VID_L;
            8'h01:   sel = SEL_VID_H;
            8'h02:   sel = SEL_PID_L;
            8'h03:   sel = SEL_PID_H;
            8'h13:   sel = SEL_STAT;
            8'h14:   sel = SEL_LATCH;
            8'h15:   sel = SEL_DBG;
            default: sel = SEL_NONE;
        endcase
        for (int i = 0; i < NCTL; i++) begin
            if (hit[i]) begin
                sel = SEL_CTL;
                idx = IDXW'(i);
                op  = op_e'(off[i]);
            end
        end
    end

endmodule

// File: rtl/ulpi_rb_irq.sv
module ulpi_rb_irq #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] status_in,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic         clr,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] latch_o
);

    typedef struct packed {
        logic [W-1:0] stat;
        logic [W-1:0] latch;
    } irq_t;

    irq_t         irq_d, irq_q;
    logic [W-1:0] ev;

    always_comb begin
        ev = (status_in & ~irq_q.stat & rise_en) | (~status_in & irq_q.stat & fall_en);
        irq_d.stat  = status_in;
        irq_d.latch = (clr ? '0 : irq_q.latch) | ev;
        if (rst) irq_d = '0;
    end

    always_ff @(posedge clk) irq_q <= irq_d;

    assign stat_o  = irq_q.stat;
    assign latch_o = irq_q.latch;

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((latch_o & $past(latch_o)) == $past(latch_o))) else $error("latch lost bit"); // R12
    AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
        ((status_in & ~stat_o & rise_en) != '0) |=>
        ((latch_o & $past(status_in & ~stat_o & rise_en)) == $past(status_in & ~stat_o & rise_en)))
        else $error("rising edge not latched"); // R12
    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr && status_in == stat_o) |=> (latch_o == '0)) else $error("latch not cleared"); // R13
    AST_STAT_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (stat_o == $past(status_in))) else $error("status sample wrong"); // R11

endmodule

// File: rtl/ulpi_phy_regbank.sv
module ulpi_phy_regbank
    import ulpi_rb_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
    parameter logic [15:0] PRODUCT_ID = 16'h0C3D,
    parameter logic [7:0]  FUNC_RST   = 8'h41,
    parameter logic [7:0]  IFC_RST    = 8'h00,
    parameter logic [7:0]  OTG_RST    = 8'h06
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic       cmd_write,
    input  logic [5:0] cmd_addr,
    input  logic [7:0] cmd_wdata,
    input  logic       ext_valid,
    input  logic [7:0] ext_addr,
    input  logic [7:0] status_in,
    input  logic [7:0] debug_in,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic [7:0] func_ctrl,
    output logic [7:0] iface_ctrl,
    output logic [7:0] otg_ctrl
);

    localparam int IER_IDX = 3;
    localparam int IEF_IDX = 4;

    typedef struct packed {
        logic                     pend;
        logic                     pend_wr;
        logic [NCTL-1:0][DW-1:0]  ctl;
        logic [DW-1:0]            rdata;
        logic                     rvalid;
    } bank_t;

    bank_t           bank_d, bank_q;
    logic            acc_go;
    logic            acc_wr;
    logic [7:0]      acc_addr;
    sel_e            dec_sel;
    op_e             dec_op;
    logic [IDXW-1:0] dec_idx;
    logic            latch_clr;
    logic [DW-1:0]   stat_v;
    logic [DW-1:0]   latch_v;

    ulpi_rb_decode i_decode (
        .addr (acc_addr),
        .sel  (dec_sel),
        .op   (dec_op),
        .idx  (dec_idx)
    );

    ulpi_rb_irq #(.W(DW)) i_irq (
        .clk       (clk),
        .rst       (rst),
        .status_in (status_in),
        .rise_en   (bank_q.ctl[IER_IDX]),
        .fall_en   (bank_q.ctl[IEF_IDX]),
        .clr       (latch_clr),
        .stat_o    (stat_v),
        .latch_o   (latch_v)
    );

    // Resolve the effective access: immediate command or escape-follow-up cycle.
    always_comb begin
        acc_go   = 1'b0;
        acc_wr   = 1'b0;
        acc_addr = '0;
        if (cmd_valid) begin
            if (cmd_addr != ESC_ADDR) begin
                acc_go   = 1'b1;
                acc_wr   = cmd_write;
                acc_addr = {2'b00, cmd_addr};
            end
        end else if (bank_q.pend && ext_valid) begin
            acc_go   = 1'b1;
            acc_wr   = bank_q.pend_wr;
            acc_addr = ext_addr;
        end
        latch_clr = acc_go && !acc_wr && (dec_sel == SEL_LATCH);
    end

    always_comb begin
        bank_d        = bank_q;
        bank_d.rvalid = 1'b0;
        bank_d.pend   = cmd_valid && (cmd_addr == ESC_ADDR);
        if (cmd_valid && cmd_addr == ESC_ADDR) bank_d.pend_wr = cmd_write;

        if (acc_go && acc_wr && dec_sel == SEL_CTL) begin
            case (dec_op)
                OP_SET:  bank_d.ctl[dec_idx] = bank_q.ctl[dec_idx] | cmd_wdata;
                OP_CLR:  bank_d.ctl[dec_idx] = bank_q.ctl[dec_idx] & ~cmd_wdata;
                default: bank_d.ctl[dec_idx] = cmd_wdata;
            endcase
        end

        if (acc_go && !acc_wr) begin
            bank_d.rvalid = 1'b1;
            case (dec_sel)
                SEL_VID_L: bank_d.rdata = VENDOR_ID[7:0];
                SEL_VID_H: bank_d.rdata = VENDOR_ID[15:8];
                SEL_PID_L: bank_d.rdata = PRODUCT_ID[7:0];
                SEL_PID_H: bank_d.rdata = PRODUCT_ID[15:8];
                SEL_CTL:   bank_d.rdata = bank_q.ctl[dec_idx];
                SEL_STAT:  bank_d.rdata = stat_v;
                SEL_LATCH: bank_d.rdata = latch_v;
                SEL_DBG:   bank_d.rdata = debug_in;
                default:   bank_d.rdata = '0;
            endcase
        end

        if (rst) begin
            bank_d        = '0;
            bank_d.ctl[0] = FUNC_RST;
            bank_d.ctl[1] = IFC_RST;
            bank_d.ctl[2] = OTG_RST;
        end
    end

    always_ff @(posedge clk) bank_q <= bank_d;

    assign rd_valid   = bank_q.rvalid;
    assign rd_data    = bank_q.rdata;
    assign func_ctrl  = bank_q.ctl[0];
    assign iface_ctrl = bank_q.ctl[1];
    assign otg_ctrl   = bank_q.ctl[2];

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (func_ctrl == FUNC_RST && iface_ctrl == IFC_RST && otg_ctrl == OTG_RST && !rd_valid))
        else $error("reset values wrong"); // R1
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_write && cmd_addr != ESC_ADDR) |=> rd_valid) else $error("read not answered"); // R8
    AST_ESC_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_addr == ESC_ADDR) |=> !rd_valid) else $error("escape produced data"); // R9
    AST_SET_ORS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_write && cmd_addr == 6'h05) |=>
        (func_ctrl == ($past(func_ctrl) | $past(cmd_wdata)))) else $error("set alias wrong"); // R4
    AST_CLR_MASKS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_write && cmd_addr == 6'h06) |=>
        (func_ctrl == ($past(func_ctrl) & ~$past(cmd_wdata)))) else $error("clear alias wrong"); // R5
    AST_RSVD_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_write && cmd_addr >= 6'h19 && cmd_addr <= 6'h2E) |=>
        ($stable(func_ctrl) && $stable(iface_ctrl) && $stable(otg_ctrl))) else $error("reserved write hit"); // R7

endmodule

// File: tb/test_ulpi_phy_regbank.sv
`timescale 1ns/1ps
module test_ulpi_phy_regbank;

    localparam logic [15:0] VID = 16'h1A2B;
    localparam logic [15:0] PID = 16'h0C3D;
    localparam logic [7:0]  DBG = 8'h5A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic       cmd_write = 1'b0;
    logic [5:0] cmd_addr = '0;
    logic [7:0] cmd_wdata = '0;
    logic       ext_valid = 1'b0;
    logic [7:0] ext_addr = '0;
    logic [7:0] status_in = '0;
    logic [7:0] debug_in = DBG;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic [7:0] func_ctrl, iface_ctrl, otg_ctrl;

    int errors = 0;
    int checks = 0;
    logic [7:0] mdl [6];
    logic [7:0] exp_stat = '0;
    logic [7:0] exp_latch = '0;

    always #2 clk = ~clk;

    ulpi_phy_regbank i_ulpi_phy_regbank (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .ext_valid(ext_valid),
        .ext_addr(ext_addr), .status_in(status_in), .debug_in(debug_in),
        .rd_valid(rd_valid), .rd_data(rd_data), .func_ctrl(func_ctrl),
        .iface_ctrl(iface_ctrl), .otg_ctrl(otg_ctrl)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic int tri_idx(logic [7:0] a);
        if (a >= 8'h04 && a <= 8'h12) return (int'(a) - 4) / 3;
        if (a >= 8'h16 && a <= 8'h18) return 5;
        return -1;
    endfunction

    function automatic int tri_off(logic [7:0] a);
        if (a <= 8'h12) return (int'(a) - 4) % 3;
        return int'(a) - 8'h16;
    endfunction

    function automatic logic [7:0] exp_rd(logic [7:0] a);
        int i;
        i = tri_idx(a);
        if (i >= 0) return mdl[i];
        case (a)
            8'h00: return VID[7:0];
            8'h01: return VID[15:8];
            8'h02: return PID[7:0];
            8'h03: return PID[15:8];
            8'h13: return exp_stat;
            8'h14: return exp_latch;
            8'h15: return DBG;
            default: return 8'h00;
        endcase
    endfunction

    task automatic mdl_write(logic [7:0] a, logic [7:0] d);
        int i;
        i = tri_idx(a);
        if (i >= 0) begin
            case (tri_off(a))
                0: mdl[i] = d;
                1: mdl[i] = mdl[i] | d;
                default: mdl[i] = mdl[i] & ~d;
            endcase
        end
    endtask

    task automatic idle();
        cmd_valid = 1'b0; cmd_write = 1'b0; ext_valid = 1'b0;
    endtask

    task automatic check_outs(string req);
        chk(req, func_ctrl, mdl[0]);
        chk(req, iface_ctrl, mdl[1]);
        chk(req, otg_ctrl, mdl[2]);
    endtask

    task automatic imm_write(logic [5:0] a, logic [7:0] d);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        idle();
        mdl_write({2'b00, a}, d);
    endtask

    task automatic imm_read(logic [5:0] a, string req);
        logic [7:0] e;
        e = exp_rd({2'b00, a});
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = a;
        @(negedge clk);
        idle();
        chk({req, " R8"}, {7'b0, rd_valid}, 8'h01);
        chk(req, rd_data, e);
        if (a == 6'h14) exp_latch = '0;
    endtask

    task automatic ext_access(logic wr, logic [7:0] a, logic [7:0] d, string req);
        logic [7:0] e;
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = 6'h2F;
        @(negedge clk);
        cmd_valid = 1'b0; ext_valid = 1'b1; ext_addr = a; cmd_wdata = d;
        e = exp_rd(a);
        @(negedge clk);
        idle();
        if (wr) mdl_write(a, d);
        else begin
            chk({req, " R8"}, {7'b0, rd_valid}, 8'h01);
            chk(req, rd_data, e);
            if (a == 8'h14) exp_latch = '0;
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        mdl[0] = 8'h41; mdl[1] = 8'h00; mdl[2] = 8'h06;
        mdl[3] = 8'h00; mdl[4] = 8'h00; mdl[5] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_outs("R1");
        chk("R1", {7'b0, rd_valid}, 8'h00);

        // R2 identification
        for (int a = 0; a < 4; a++) imm_read(6'(a), "R2");

        // R3 plain write, read at all three aliases
        imm_write(6'h07, 8'hA5);
        check_outs("R3");
        imm_read(6'h07, "R3"); imm_read(6'h08, "R3"); imm_read(6'h09, "R3");
        // R4 set alias
        imm_write(6'h08, 8'h0A);
        chk("R4", iface_ctrl, 8'hAF);
        // R5 clear alias
        imm_write(6'h09, 8'h0F);
        chk("R5", iface_ctrl, 8'hA0);
        imm_write(6'h0B, 8'h30);
        chk("R4", otg_ctrl, 8'h36);
        imm_write(6'h18, 8'hFF);
        imm_read(6'h16, "R5");

        // R6 read-only registers ignore writes
        imm_write(6'h00, 8'hFF); imm_write(6'h03, 8'hFF);
        imm_write(6'h13, 8'hFF); imm_write(6'h14, 8'hFF); imm_write(6'h15, 8'h00);
        check_outs("R6");
        imm_read(6'h00, "R6"); imm_read(6'h03, "R6");
        imm_read(6'h13, "R6"); imm_read(6'h14, "R6"); imm_read(6'h15, "R6");

        // R7 reserved and unimplemented addresses
        imm_write(6'h1A, 8'hFF); imm_write(6'h30, 8'hFF); imm_write(6'h3C, 8'hFF);
        check_outs("R7");
        imm_read(6'h1A, "R7"); imm_read(6'h2E, "R7"); imm_read(6'h30, "R7"); imm_read(6'h3F, "R7");
        ext_access(1'b1, 8'h84, 8'hFF, "R7");
        check_outs("R7");
        ext_access(1'b0, 8'h84, 8'h00, "R7");
        ext_access(1'b0, 8'h40, 8'h00, "R7");

        // R9 extended mirror
        ext_access(1'b0, 8'h00, 8'h00, "R9");
        ext_access(1'b1, 8'h16, 8'h3C, "R9");
        imm_read(6'h16, "R9");
        ext_access(1'b1, 8'h05, 8'h80, "R9");
        chk("R9", func_ctrl, mdl[0]);

        // R10 abandon by new command
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 6'h2F;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = 6'h04; ext_valid = 1'b1; ext_addr = 8'h00;
        @(negedge clk);
        idle();
        chk("R10", {7'b0, rd_valid}, 8'h01);
        chk("R10", rd_data, mdl[0]);
        // R10 abandon by missing extended address
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 6'h2F; cmd_wdata = 8'h00;
        @(negedge clk);
        idle();
        @(negedge clk);
        ext_valid = 1'b1; ext_addr = 8'h04;
        @(negedge clk);
        idle();
        chk("R10", {7'b0, rd_valid}, 8'h00);
        chk("R10", func_ctrl, mdl[0]);

        // Random mix against the model
        for (int n = 0; n < 400; n++) begin
            logic [7:0] a;
            logic [7:0] d;
            d = 8'($urandom);
            if ($urandom % 4 == 0) begin
                a = 8'($urandom);
                ext_access(($urandom % 2) == 1, a, d, "R9");
            end else begin
                a = {2'b00, 6'($urandom)};
                if (a == 8'h2F) a = 8'h16;
                if ($urandom % 2 == 1) imm_write(6'(a), d);
                else imm_read(6'(a), "R3");
            end
        end
        check_outs("R3");

        // R11/R12/R13 interrupt path
        imm_write(6'h0D, 8'h01);
        imm_write(6'h10, 8'h02);
        status_in = 8'h03;
        @(negedge clk);
        exp_stat = 8'h03; exp_latch = 8'h01;
        imm_read(6'h13, "R11");
        imm_read(6'h14, "R12");
        imm_read(6'h14, "R13");
        status_in = 8'h00;
        @(negedge clk);
        exp_stat = 8'h00; exp_latch = 8'h02;
        imm_read(6'h14, "R12");
        status_in = 8'h01;
        imm_read(6'h14, "R13");
        exp_stat = 8'h01; exp_latch = 8'h01;
        imm_read(6'h14, "R13");
        imm_read(6'h13, "R11");

        summary();
    end

endmodule